// File: doc/BRIEF.md
# Host Bridge Control Register File with Memory-Window Translation

This block holds the eight 32-bit control words of a host bridge and turns an offset inside each of three memory windows into a 32-bit downstream bus address. Software reaches the words through a simple register port: an address, write data and a write strobe go in, and read data comes back combinationally for whatever address is presented. Writes land at the clock edge. A write to an offset that names no register changes nothing and raises a one-cycle error pulse.

Each window has a map word that sets where the window lands on the downstream bus. A single variant input picks how that word is read. In the nibble variant, the four low bits of the map word become the top four address bits. In the masked variant, the map word is cleared below the window size and used as the base. In both variants the incoming offset is first cut to the window size and then added to the base. The variant input selects only a path through combinational logic and holds no state, so the translation follows it at once.

Top module: `hbr_ctrl_xlat`

## Requirements
- R1: A synchronous active-high reset clears all eight registers, so every valid read returns 0. In the nibble variant, every window then maps offset 0 to address 0.
- R2: The registers are byte offsets 0x00, 0x04 and 0x08 (map words of windows 0, 1 and 2), 0x0C (identity word), 0x10 (flag word) and 0x14, 0x18 and 0x1C (secondary words 0, 1 and 2). A write to one of these stores all 32 bits, and a read returns them.
- R3: Reading any address that is not one of the eight offsets returns 0. This covers addresses above 0x1C and addresses whose two low bits are not 00, because only whole-word accesses exist.
- R4: A write to an address that is not one of the eight offsets leaves every register unchanged. It drives `reg_err` high for exactly the one cycle after the write edge.
- R5: A write to a valid offset never raises `reg_err`, and `reg_err` is never high unless an invalid write occurred on the edge before.
- R6: With `variant_alt`=0, the window sizes are 0x0C000000, 0x10000000 and 0x10000000. `win_addr[w]` = {map[3:0], 28'h0} + (`win_off[w]` & (size-1)), and map bits 31:4 are ignored.
- R7: With `variant_alt`=1, the window sizes are 0x01000000, 0x04000000 and 0x08000000. `win_addr[w]` = (map & ~(size-1)) + (`win_off[w]` & (size-1)).
- R8: A write to a map word changes that window's translation starting right after the write edge, and not before it.
- R9: Changing `variant_alt` or `win_off` changes `win_addr` in the same cycle, with no clock edge needed.
- R10: `reg_rdata` follows `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_alt | input | 1 | 0 selects the nibble translation, 1 selects the masked translation |
| reg_addr | input | ADDR_W (12) | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_rdata | output | 32 | Combinational read data |
| reg_err | output | 1 | One-cycle pulse after a write to an undefined offset |
| win_off | input | 3x32 | Incoming offset for each window |
| win_addr | output | 3x32 | Translated downstream address for each window |

## Verification
The bench sweeps every byte address from 0x00 to 0x7F after loading distinct patterns. A decoder that ignored the two low bits would alias misaligned reads onto real registers, and one that ignored the upper bits would wrap 0x20 back onto window map 0. Invalid writes are followed by a full read-back, which catches a decoder that stores them anyway. The width of the error pulse is also checked, which catches an error flag that sticks high. Each window is swept through all 16 nibbles with offsets at 0, size-1, size and all ones. The first window's 0x0C000000 size is the case that exposes a mask wrongly taken from the next power of two. Finally, the bench samples the translation on both sides of a map write edge, and again across a variant flip with no clock in between. This catches a translator that adds a pipeline register or latches the variant.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int WORD_W    = 32;
    localparam int NWIN      = 3;
    localparam int NREG      = 8;
    localparam int REG_IDX_W = $clog2(NREG);
    localparam int NIB_W     = 4;
    localparam int NIB_LSB   = WORD_W - NIB_W;

    typedef logic [WORD_W-1:0] word_t;

    // Register index = byte offset / 4
    typedef enum logic [REG_IDX_W-1:0] {
        RIX_WMAP0 = 3'd0,
        RIX_WMAP1 = 3'd1,
        RIX_WMAP2 = 3'd2,
        RIX_IDENT = 3'd3,
        RIX_FLAGS = 3'd4,
        RIX_SMAP0 = 3'd5,
        RIX_SMAP1 = 3'd6,
        RIX_SMAP2 = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic     hit;
        reg_idx_e idx;
    } reg_sel_t;

    typedef struct packed {
        word_t base;
        word_t span;
    } xlat_t;

    // Window size by variant and window number
    function automatic word_t win_size(input logic alt, input int unsigned w);
        word_t s;
        if (alt) begin
            case (w)
                0:       s = 32'h0100_0000;
                1:       s = 32'h0400_0000;
                default: s = 32'h0800_0000;
            endcase
        end else begin
            case (w)
                0:       s = 32'h0C00_0000;
                default: s = 32'h1000_0000;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/hbr_regfile.sv
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  word_t                    reg_wdata,
    input  logic                     reg_we,
    output word_t                    reg_rdata,
    output logic                     reg_err,
    output logic [NWIN-1:0][WORD_W-1:0] win_map
);

    localparam int IDX_LSB = 2;
    localparam int IDX_MSB = IDX_LSB + REG_IDX_W - 1;

    reg_sel_t sel;
    word_t    reg_q [NREG];

    // Whole-word decode: upper bits zero and low two bits zero
    always_comb begin
        sel.hit = (reg_addr[ADDR_W-1:IDX_MSB+1] == '0) &&
                  (reg_addr[IDX_LSB-1:0] == '0);
        sel.idx = reg_idx_e'(reg_addr[IDX_MSB:IDX_LSB]);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q[g] <= '0;
            end else if (reg_we && sel.hit && (sel.idx == reg_idx_e'(g))) begin
                reg_q[g] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = sel.hit ? reg_q[sel.idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_err <= 1'b0;
        end else begin
            reg_err <= reg_we && !sel.hit;
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_map
        assign win_map[w] = reg_q[int'(RIX_WMAP0) + w];
    end

endmodule

// File: rtl/hbr_win_xlat.sv
module hbr_win_xlat
    import hbr_pkg::*;
#(
    parameter word_t SIZE_PRI = 32'h1000_0000,
    parameter word_t SIZE_ALT = 32'h0100_0000
) (
    input  logic  variant_alt,
    input  word_t map_val,
    input  word_t offset,
    output word_t dn_addr
);

    localparam word_t MASK_PRI = SIZE_PRI - 32'd1;
    localparam word_t MASK_ALT = SIZE_ALT - 32'd1;

    xlat_t x;

    always_comb begin
        if (variant_alt) begin
            x.base = map_val & ~MASK_ALT;
            x.span = offset & MASK_ALT;
        end else begin
            x.base = {map_val[NIB_W-1:0], {NIB_LSB{1'b0}}};
            x.span = offset & MASK_PRI;
        end
        dn_addr = x.base + x.span;
    end

endmodule

// File: rtl/hbr_ctrl_xlat.sv
module hbr_ctrl_xlat
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        variant_alt,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    input  logic                        reg_we,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic                        reg_err,
    input  logic [NWIN-1:0][WORD_W-1:0] win_off,
    output logic [NWIN-1:0][WORD_W-1:0] win_addr
);

    logic [NWIN-1:0][WORD_W-1:0] win_map;

    hbr_regfile #(.ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .win_map   (win_map)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        hbr_win_xlat #(
            .SIZE_PRI (win_size(1'b0, w)),
            .SIZE_ALT (win_size(1'b1, w))
        ) i_xlat (
            .variant_alt (variant_alt),
            .map_val     (win_map[w]),
            .offset      (win_off[w]),
            .dn_addr     (win_addr[w])
        );
    end

endmodule

// File: rtl/hbr_ctrl_xlat_chk.sv
module hbr_ctrl_xlat_chk
    import hbr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        variant_alt,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [WORD_W-1:0]           reg_wdata,
    input logic                        reg_we,
    input logic [WORD_W-1:0]           reg_rdata,
    input logic                        reg_err,
    input logic [NWIN-1:0][WORD_W-1:0] win_off,
    input logic [NWIN-1:0][WORD_W-1:0] win_addr
);

    logic addr_ok;
    assign addr_ok = (reg_addr < ADDR_W'(32)) && (reg_addr[1:0] == 2'b00);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_rdata == '0));

    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(reg_we && addr_ok) && (reg_addr == $past(reg_addr)))
        |-> (reg_rdata == $past(reg_wdata)));

    assert_bad_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !addr_ok |-> (reg_rdata == '0));

    assert_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !addr_ok) |=> reg_err);

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
        reg_err |-> $past(reg_we && !addr_ok));

    for (genvar w = 0; w < NWIN; w++) begin : g_chk
        localparam logic [WORD_W-1:0] ALT_MASK = win_size(1'b1, w) - 32'd1;

        assert_nibble_hold_R6: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && !variant_alt && $past(!variant_alt) && !$past(reg_we))
            |-> (win_addr[w][WORD_W-1:NIB_LSB] == $past(win_addr[w][WORD_W-1:NIB_LSB])));

        assert_alt_span_R7: assert property (@(posedge clk) disable iff (rst)
            variant_alt |-> (((win_addr[w] ^ win_off[w]) & ALT_MASK) == '0));
    end

endmodule

bind hbr_ctrl_xlat hbr_ctrl_xlat_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_hbr_ctrl_xlat.sv
`timescale 1ns/1ps
module test_hbr_ctrl_xlat;

    localparam int ADDR_W = 12;
    localparam int NW     = 3;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   variant_alt = 1'b0;
    logic [ADDR_W-1:0]      reg_addr = '0;
    logic [31:0]            reg_wdata = '0;
    logic                   reg_we = 1'b0;
    logic [31:0]            reg_rdata;
    logic                   reg_err;
    logic [NW-1:0][31:0]    win_off = '0;
    logic [NW-1:0][31:0]    win_addr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] shadow [8];

    always #2.5 clk = ~clk;

    hbr_ctrl_xlat #(.ADDR_W(ADDR_W)) i_hbr_ctrl_xlat (
        .clk(clk), .rst(rst), .variant_alt(variant_alt),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .reg_err(reg_err),
        .win_off(win_off), .win_addr(win_addr)
    );

    function automatic logic [31:0] size_of(input logic alt, input int w);
        if (alt) return (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
        return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    endfunction

    function automatic logic [31:0] model(input logic alt, input int w,
                                          input logic [31:0] map, input logic [31:0] off);
        logic [31:0] m;
        logic [31:0] b;
        m = size_of(alt, w) - 32'd1;
        b = alt ? (map & ~m) : {map[3:0], 28'h0};
        return b + (off & m);
    endfunction

    function automatic bit addr_valid(input int a);
        return (a < 32) && ((a % 4) == 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        if (addr_valid(a)) shadow[a / 4] = d;
    endtask

    task automatic read_chk(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 8; i++) read_chk(i * 4, 32'h0, "R1 reset read");
        #1;
        for (int w = 0; w < NW; w++) check("R1 reset translation", win_addr[w], 32'h0);
        check("R1 reset err", {31'd0, reg_err}, 32'd0);

        // R2 / R5: distinct patterns into all registers
        for (int i = 0; i < 8; i++) begin
            bus_write(i * 4, 32'h9E37_79B9 * (i + 1) ^ 32'h8000_0001);
            check("R5 valid write no error", {31'd0, reg_err}, 32'd0);
        end
        for (int i = 0; i < 8; i++) read_chk(i * 4, shadow[i], "R2 readback");

        // R3 / R10: exhaustive address sweep
        for (int a = 0; a < 128; a++)
            read_chk(a, addr_valid(a) ? shadow[a / 4] : 32'h0, addr_valid(a) ? "R10 read" : "R3 bad read");
        read_chk(12'hFFC, 32'h0, "R3 high read");
        read_chk(12'h800, 32'h0, "R3 high read");

        // R4: invalid writes
        begin
            int bad [6] = '{32, 3, 64, 13, 12'hFFC, 30};
            foreach (bad[k]) begin
                bus_write(bad[k], 32'hDEAD_BEEF);
                check("R4 error pulse", {31'd0, reg_err}, 32'd1);
                @(negedge clk);
                check("R4 pulse one cycle", {31'd0, reg_err}, 32'd0);
            end
        end
        for (int i = 0; i < 8; i++) read_chk(i * 4, shadow[i], "R4 no register changed");

        // R6: nibble variant sweep
        variant_alt = 1'b0;
        for (int w = 0; w < NW; w++) begin
            for (int n = 0; n < 16; n++) begin
                logic [31:0] mp;
                logic [31:0] offs [6];
                mp = {28'hA5C3_96F, 4'(n)};
                offs = '{32'h0, 32'h1, size_of(1'b0, w) - 32'd1, size_of(1'b0, w),
                         32'hFFFF_FFFF, 32'h1234_5678};
                bus_write(w * 4, mp);
                foreach (offs[k]) begin
                    win_off[w] = offs[k];
                    #1;
                    check("R6 nibble translation", win_addr[w], model(1'b0, w, mp, offs[k]));
                end
            end
        end

        // R7: masked variant sweep
        variant_alt = 1'b1;
        for (int w = 0; w < NW; w++) begin
            logic [31:0] maps [5];
            maps = '{32'h0, 32'hFFFF_FFFF, 32'h4567_89AB, 32'h8000_0000, 32'h0FFF_FFFF};
            foreach (maps[j]) begin
                logic [31:0] offs [5];
                offs = '{32'h0, size_of(1'b1, w) - 32'd1, size_of(1'b1, w),
                         32'hFFFF_FFFF, 32'h00AB_CDEF};
                bus_write(w * 4, maps[j]);
                foreach (offs[k]) begin
                    win_off[w] = offs[k];
                    #1;
                    check("R7 masked translation", win_addr[w], model(1'b1, w, maps[j], offs[k]));
                end
            end
        end

        // R9: variant flip without a clock edge
        bus_write(4, 32'h7654_321B);
        win_off[1] = 32'h0ABC_DEF1;
        variant_alt = 1'b0;
        #1;
        check("R9 flip to nibble", win_addr[1], model(1'b0, 1, 32'h7654_321B, 32'h0ABC_DEF1));
        variant_alt = 1'b1;
        #1;
        check("R9 flip to masked", win_addr[1], model(1'b1, 1, 32'h7654_321B, 32'h0ABC_DEF1));

        // R8: translation changes exactly at the write edge
        variant_alt = 1'b0;
        bus_write(0, 32'h0000_0003);
        win_off[0] = 32'h0000_0010;
        @(negedge clk);
        reg_addr  = ADDR_W'(0);
        reg_wdata = 32'h0000_0009;
        reg_we    = 1'b1;
        #1;
        check("R8 before edge", win_addr[0], 32'h3000_0010);
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        check("R8 after edge", win_addr[0], 32'h9000_0010);

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) read_chk(i * 4, 32'h0, "R1 second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule